// File: doc/BRIEF.md
# Lookahead Readiness Pointer Tracker

This block follows a circular store queue and reports the oldest entry that is still waiting for its operand, either its address or its data, depending on which valid vector is wired in. It holds one wrap-flagged pointer. Each cycle it looks at a short run of consecutive entries that starts at the pointer. It then moves the pointer forward to the first entry in that run that is not ready. If every entry in the run is ready, it moves by the full length of the run. Issue logic downstream treats every entry older than this pointer as ready.

When a pipeline redirect arrives, the pointer is reloaded rather than stepped. The reload target is the commit pointer if that pointer lies ahead of the dequeue pointer; otherwise it is the dequeue pointer value for the next cycle. Alongside the pointer, the block also presents a per-entry readiness vector one cycle late. All pins are plain control and status signals. The block has no streaming interface, so there is no back-pressure.

Top module: `rdyp_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the ready pointer is 0 (flag 0, index 0) and the readiness vector is all zeros.
- R2: A pointer value p counts as ready when three conditions all hold: entry p mod DEPTH has its allocated bit set, that entry has either its mmio bit or its valid bit set, and p (flag and index together) differs from the enqueue pointer. On a clock edge without redirect, the pointer moves to the first non-ready position among p, p+1, …, p+WIN-1, using the inputs sampled at that edge.
- R3: If the ready pointer equals the enqueue pointer and there is no redirect, the pointer holds its value at the next edge. The pointer never steps past the enqueue pointer.
- R4: Without redirect, the pointer advances by exactly WIN when all WIN examined positions are ready. In every non-redirect cycle the step lies between 0 and WIN.
- R5: On redirect, the pointer loads the commit pointer when the commit pointer is younger than the dequeue pointer.
- R6: On redirect, if the commit pointer is older than or equal to the dequeue pointer, the pointer loads the next-cycle dequeue pointer input.
- R7: When redirect is asserted in a cycle where the window would also have advanced the pointer, the redirect target wins.
- R8: Bit i of the readiness vector equals allocated[i] AND (mmio[i] OR valid[i]), taken from the previous edge. The enqueue pointer has no effect on this vector.
- R9: Pointers are IDXW+1 bits wide, where IDXW = log2(DEPTH). Bit IDXW is a wrap flag and the lower bits are the index. Stepping past index DEPTH-1 wraps the index and toggles the flag. With equal flags, the larger index is younger; with different flags, the smaller index is younger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_i | input | 1 | Flush pulse that reloads the pointer |
| enq_ptr_i | input | IDXW+1 | Enqueue pointer (flag and index) |
| cmt_ptr_i | input | IDXW+1 | Commit pointer |
| deq_ptr_i | input | IDXW+1 | Current dequeue pointer |
| deq_ptr_nxt_i | input | IDXW+1 | Dequeue pointer value for the next cycle |
| alloc_i | input | DEPTH | Per-entry allocated bits |
| mmio_i | input | DEPTH | Per-entry uncached-access bits |
| valid_i | input | DEPTH | Per-entry operand-valid bits |
| rdy_ptr_o | output | IDXW+1 | Oldest not-ready position |
| rdy_vec_o | output | DEPTH | Per-entry readiness, registered |

## Verification
The bench builds the block with DEPTH 16 and WIN 4. With these values a fully ready queue is crossed in four steps, so wrap-flag toggling happens within a handful of cycles. The enqueue pointer can therefore sit in either flag half relative to the ready pointer. Directed sequences place a blocker at a specific window offset, use an mmio entry whose valid bit is clear, and drive redirects with the commit pointer ahead of, equal to and behind the dequeue pointer. A long randomized phase then compares against a one-entry-at-a-time scan on every cycle.

// File: rtl/rdyp_pkg.sv
package rdyp_pkg;

  typedef enum logic [1:0] {
    SRC_STEP = 2'd0,
    SRC_CMT  = 2'd1,
    SRC_DEQ  = 2'd2
  } rdyp_src_e;

endpackage

// File: rtl/rdyp_window.sv
module rdyp_window #(
  parameter int DEPTH = 16,
  parameter int WIN   = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1,
  localparam int CW   = $clog2(WIN + 1)
) (
  input  logic [PTRW-1:0]  ptr_i,
  input  logic [PTRW-1:0]  enq_i,
  input  logic [DEPTH-1:0] alloc_i,
  input  logic [DEPTH-1:0] mmio_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [CW-1:0]    step_o,
  output logic [PTRW-1:0]  next_o
);

  logic [WIN-1:0] ok;

  // One comparator slice per examined position.
  for (genvar k = 0; k < WIN; k++) begin : g_slot
    logic [PTRW-1:0] pos;
    logic [IDXW-1:0] idx;
    assign pos   = ptr_i + PTRW'(k);
    assign idx   = pos[IDXW-1:0];
    assign ok[k] = alloc_i[idx] & (mmio_i[idx] | valid_i[idx]) & (pos != enq_i);
  end

  // First not-ready slot; the implicit sentinel beyond the window yields WIN.
  always_comb begin
    step_o = CW'(WIN);
    for (int k = WIN - 1; k >= 0; k--) begin
      if (!ok[k]) step_o = CW'(k);
    end
  end

  assign next_o = ptr_i + PTRW'(step_o);

endmodule

// File: rtl/rdyp_restore.sv
module rdyp_restore #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1
) (
  input  logic [PTRW-1:0] cmt_i,
  input  logic [PTRW-1:0] deq_i,
  input  logic [PTRW-1:0] deq_nxt_i,
  output logic            cmt_sel_o,
  output logic [PTRW-1:0] tgt_o
);

  logic same_flag;
  logic idx_gt;
  logic idx_lt;

  assign same_flag = cmt_i[IDXW] == deq_i[IDXW];
  assign idx_gt    = cmt_i[IDXW-1:0] > deq_i[IDXW-1:0];
  assign idx_lt    = cmt_i[IDXW-1:0] < deq_i[IDXW-1:0];

  // Commit pointer is younger: larger index in the same lap, smaller across laps.
  assign cmt_sel_o = same_flag ? idx_gt : idx_lt;
  assign tgt_o     = cmt_sel_o ? cmt_i : deq_nxt_i;

endmodule

// File: rtl/rdyp_vec_reg.sv
module rdyp_vec_reg #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_i,
  input  logic [DEPTH-1:0] mmio_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] vec_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) vec_o[i] <= 1'b0;
      else        vec_o[i] <= alloc_i[i] & (mmio_i[i] | valid_i[i]);
    end
  end

  // R8: an empty queue yields an empty vector one cycle later
  a_r8_empty_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i == '0) |=> (vec_o == '0));

endmodule

// File: rtl/rdyp_tracker.sv
module rdyp_tracker
  import rdyp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIN   = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PTRW = IDXW + 1,
  localparam int CW   = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redirect_i,
  input  logic [PTRW-1:0]  enq_ptr_i,
  input  logic [PTRW-1:0]  cmt_ptr_i,
  input  logic [PTRW-1:0]  deq_ptr_i,
  input  logic [PTRW-1:0]  deq_ptr_nxt_i,
  input  logic [DEPTH-1:0] alloc_i,
  input  logic [DEPTH-1:0] mmio_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [PTRW-1:0]  rdy_ptr_o,
  output logic [DEPTH-1:0] rdy_vec_o
);

  logic [PTRW-1:0] ptr_q;
  logic [PTRW-1:0] step_ptr;
  logic [CW-1:0]   step_cnt;
  logic [PTRW-1:0] restore_ptr;
  logic            cmt_sel;
  rdyp_src_e       src;
  logic [PTRW-1:0] ptr_d;

  rdyp_window #(.DEPTH(DEPTH), .WIN(WIN)) u_window (
    .ptr_i   (ptr_q),
    .enq_i   (enq_ptr_i),
    .alloc_i (alloc_i),
    .mmio_i  (mmio_i),
    .valid_i (valid_i),
    .step_o  (step_cnt),
    .next_o  (step_ptr)
  );

  rdyp_restore #(.DEPTH(DEPTH)) u_restore (
    .cmt_i     (cmt_ptr_i),
    .deq_i     (deq_ptr_i),
    .deq_nxt_i (deq_ptr_nxt_i),
    .cmt_sel_o (cmt_sel),
    .tgt_o     (restore_ptr)
  );

  rdyp_vec_reg #(.DEPTH(DEPTH)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (alloc_i),
    .mmio_i  (mmio_i),
    .valid_i (valid_i),
    .vec_o   (rdy_vec_o)
  );

  // Redirect outranks the window step (R7).
  always_comb begin
    if (!redirect_i)  src = SRC_STEP;
    else if (cmt_sel) src = SRC_CMT;
    else              src = SRC_DEQ;
  end

  always_comb begin
    unique case (src)
      SRC_STEP: ptr_d = step_ptr;
      default:  ptr_d = restore_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign rdy_ptr_o = ptr_q;

  // R2: an unallocated entry under the pointer pins it in place
  a_r2_stall_unalloc: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && !alloc_i[rdy_ptr_o[IDXW-1:0]]) |=> $stable(rdy_ptr_o));

  // R3: the pointer does not move beyond the enqueue pointer
  a_r3_hold_at_enq: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && rdy_ptr_o == enq_ptr_i) |=> $stable(rdy_ptr_o));

  // R4: a step never exceeds the window length
  a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_i |=> (PTRW'(rdy_ptr_o - $past(rdy_ptr_o)) <= PTRW'(WIN)));

  // R5 and R6: a redirect lands on one of the two restore sources
  a_r6_redirect_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (rdy_ptr_o == $past(cmt_ptr_i)) || (rdy_ptr_o == $past(deq_ptr_nxt_i)));

endmodule

// File: tb/rdyp_tracker_bench.sv
module rdyp_tracker_bench;
  localparam int D  = 16;
  localparam int W  = 4;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redir = 1'b0;
  logic [PW-1:0] enq = '0, cmt = '0, deq = '0, deqn = '0;
  logic [D-1:0] a_v = '0, m_v = '0, v_v = '0;
  logic [PW-1:0] rdy_ptr;
  logic [D-1:0]  rdy_vec;

  int checks = 0;
  int errors = 0;
  int ref_ptr = 0;
  logic [D-1:0] ref_vec = '0;
  bit done = 0;

  always #4 clk = ~clk;

  rdyp_tracker #(.DEPTH(D), .WIN(W)) u_rdyp_tracker (
    .clk(clk), .rst_n(rst_n), .redirect_i(redir),
    .enq_ptr_i(enq), .cmt_ptr_i(cmt), .deq_ptr_i(deq), .deq_ptr_nxt_i(deqn),
    .alloc_i(a_v), .mmio_i(m_v), .valid_i(v_v),
    .rdy_ptr_o(rdy_ptr), .rdy_vec_o(rdy_vec)
  );

  function automatic bit younger(int a, int b);
    if ((a / D) == (b / D)) return (a % D) > (b % D);
    return (a % D) < (b % D);
  endfunction

  function automatic bit slot_ready(int p);
    int i = p % D;
    return a_v[i] && (m_v[i] || v_v[i]) && (p != int'(enq));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance one clock, update the reference, compare after the edge.
  task automatic step(string tag);
    int nxt;
    int k;
    logic [D-1:0] nv;
    if (redir) begin
      nxt = younger(int'(cmt), int'(deq)) ? int'(cmt) : int'(deqn);
    end else begin
      k = 0;
      while (k < W && slot_ready((ref_ptr + k) % (2 * D))) k++;
      nxt = (ref_ptr + k) % (2 * D);
    end
    nv = a_v & (m_v | v_v);
    @(posedge clk);
    ref_ptr = nxt;
    ref_vec = nv;
    @(negedge clk);
    check({tag, " R2 ptr vs scan"}, int'(rdy_ptr), ref_ptr);
    checks++;
    if (rdy_vec !== ref_vec) begin
      errors++;
      $display("FAIL R8 vec actual=%h expected=%h", rdy_vec, ref_vec);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ptr", int'(rdy_ptr), 0);
    check("R1 reset vec", int'(rdy_vec), 0);
    rst_n = 1'b1;
    step("R1");
    check("R1 first cycle ptr", int'(rdy_ptr), 0);

    // Full queue, all ready: steps of four, wrap to flag 1, stop at enqueue.
    a_v = '1; v_v = '1; enq = 5'd16;
    step("R4"); check("R4 full window step", int'(rdy_ptr), 4);
    step("R4"); check("R4 second step", int'(rdy_ptr), 8);
    step("R4"); step("R9");
    check("R9 reaches flag 1 idx 0", int'(rdy_ptr), 16);
    check("R8 all-ready vector", int'(rdy_vec), 16'hFFFF);
    step("R3"); check("R3 holds at enqueue", int'(rdy_ptr), 16);

    // Redirect with commit younger than dequeue.
    redir = 1'b1; cmt = 5'd3; deq = 5'd0; deqn = 5'd1;
    step("R5"); redir = 1'b0;
    check("R5 restore to commit", int'(rdy_ptr), 3);

    // Blocker at entry 5.
    v_v[5] = 1'b0;
    step("R2"); check("R2 stops at blocker", int'(rdy_ptr), 5);
    step("R2"); check("R2 stays on blocker", int'(rdy_ptr), 5);
    check("R8 invalid entry bit clear", int'(rdy_vec[5]), 0);
    m_v[5] = 1'b1;
    a_v[10] = 1'b0;
    step("R2"); check("R2 mmio entry counts ready", int'(rdy_ptr), 9);
    step("R2"); check("R2 unallocated entry blocks", int'(rdy_ptr), 10);
    check("R8 unallocated valid entry bit clear", int'(rdy_vec[10]), 0);
    a_v[10] = 1'b1;

    // Redirect with equal and older commit pointer.
    redir = 1'b1; cmt = 5'd2; deq = 5'd2; deqn = 5'd3;
    step("R6"); check("R6 equal pointers use next dequeue", int'(rdy_ptr), 3);
    cmt = 5'd4; deq = 5'd6; deqn = 5'd7;
    step("R6"); check("R6 older commit uses next dequeue", int'(rdy_ptr), 7);
    cmt = 5'd18; deq = 5'd20; deqn = 5'd21; enq = 5'd28;
    step("R6"); check("R6 older commit across same lap", int'(rdy_ptr), 21);

    // Redirect while the window is fully ready: redirect wins.
    cmt = 5'd14; deq = 5'd10; deqn = 5'd10; enq = 5'd22;
    step("R7"); redir = 1'b0;
    check("R7 redirect beats step", int'(rdy_ptr), 14);
    step("R9"); check("R9 wrap toggles flag", int'(rdy_ptr), 18);
    step("R3"); check("R3 stops at wrapped enqueue", int'(rdy_ptr), 22);
    step("R3"); check("R3 still held", int'(rdy_ptr), 22);

    // Enqueue pointer does not affect the vector.
    enq = 5'd0; a_v = 16'h00F0; v_v = 16'h0030; m_v = 16'h0040;
    step("R8"); check("R8 vector content", int'(rdy_vec), 16'h0070);

    // Randomized phase.
    for (int n = 0; n < 3000; n++) begin
      a_v   = 16'($urandom) | 16'($urandom);
      v_v   = 16'($urandom) | 16'($urandom);
      m_v   = 16'($urandom) & 16'($urandom) & 16'($urandom);
      enq   = 5'($urandom);
      cmt   = 5'($urandom);
      deq   = 5'($urandom);
      deqn  = 5'($urandom);
      redir = ($urandom % 8) == 0;
      step(redir ? "R5 R6 random" : "R2 random");
    end
    redir = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule